// File: doc/BRIEF.md
# Strict Clos Middle-Stage Route Allocator

This block assigns paths through a three-stage Clos fabric with `N = n*m` ports. The fabric has `m` ingress switches of size n x k, `k` middle switches of size m x m and `m` egress switches of size k x n. Ingress switch `j` drives input `j` of every middle switch, and every middle switch drives one link into each egress switch. A connect request names an input port and an output port. The allocator derives the ingress and egress switch, looks up which middle switches still have a free link on both sides, takes the lowest-numbered one, records the path and returns its index. A disconnect request names the input port and releases the recorded path.

When the fabric has at least `2n-1` middle switches, at most `n-1` links can be busy on each side of a new connection. One middle switch therefore stays free on both sides, and no existing path has to move. The configuration output reports whether the parameters meet this bound. Choosing the order of requests and rearranging existing paths are left to the surrounding logic. Each request is answered exactly one clock later.

Top module: `clos_route_alloc`

## Requirements
- R1: While reset is active, and in the cycle after it, `rsp_valid` is 0 and every link is free, so the first connect after reset returns middle index 0.
- R2: A request presented with `req_valid`=1 gets exactly one response, with `rsp_valid`=1 in the following cycle. `rsp_valid` is 0 in every cycle that does not follow a request.
- R3: A connect (`req_op`=0) with both ports in range and unconnected uses ingress switch `req_in / n` and egress switch `req_out / n` (integer division). It returns `rsp_ok`=1 and the lowest middle index whose uplink from that ingress switch and downlink to that egress switch are both free, then marks both links busy.
- R4: A connect whose input port already has a path, or whose output port is already in use, returns `rsp_ok`=0 and `rsp_mid`=0 and leaves every path and link unchanged.
- R5: A disconnect (`req_op`=1) uses only `req_in`; `req_out` has no effect. If the input has a path, the block frees that path's uplink, its downlink and both ports, and returns `rsp_ok`=1 with the middle index that was freed. If the input has no path, the block returns `rsp_ok`=0 and `rsp_mid`=0 and changes nothing.
- R6: `cfg_strict` is 1 exactly when `k >= 2n-1`. With `cfg_strict`=1, a connect whose ports are in range and unconnected never fails, whatever paths already exist.
- R7: A request naming a port index of `n*m` or more returns `rsp_ok`=0 and `rsp_mid`=0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 1 | 0 = connect, 1 = disconnect |
| req_in | input | PW = clog2(n*m) | Input port of the request |
| req_out | input | PW | Output port of a connect request; ignored on disconnect |
| rsp_valid | output | 1 | A response is present this cycle |
| rsp_ok | output | 1 | 1 = request carried out, 0 = refused |
| rsp_mid | output | MW = clog2(k) | Middle switch assigned or freed; 0 on refusal |
| cfg_strict | output | 1 | Parameters satisfy k >= 2n-1 |

## Verification
The hardest state to reach is the one where an ingress switch and an egress switch each already have `n-1` busy links on disjoint middle switches. A new connection between them must then take the last middle switch, index `2n-2`. The ports cannot set this up directly. It builds up only through a long mix of connects and disconnects that leaves occupancy high and fragmented. The stimulus therefore runs thousands of random requests weighted towards connect, with some out-of-range and already-used ports mixed in. A behavioural model of paths and links predicts every response and checks it each clock.

// File: rtl/clos_pkg.sv
// Shared definitions for the Clos route allocator.
// Assumes: operation codes are one bit wide at the block's ports.
package clos_pkg;

    typedef enum logic {
        ROUTE_CONNECT    = 1'b0,
        ROUTE_DISCONNECT = 1'b1
    } route_op_e;

    // Width of an index into 'count' items, never below one bit.
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/clos_port_map.sv
// Maps a port index to the outer-stage switch that serves it.
// Assumes: ports are numbered switch by switch, N_PER ports per switch.
// Out-of-range ports give switch 0 and in_range = 0.
module clos_port_map
    import clos_pkg::*;
#(
    parameter int N_PER = 3,
    parameter int M_SW  = 3,
    localparam int N_PORTS = N_PER * M_SW,
    localparam int PW      = idx_width(N_PORTS),
    localparam int SW      = idx_width(M_SW)
) (
    input  logic [PW-1:0] port,
    output logic [SW-1:0] sw,
    output logic          in_range
);

    int quot;

    // Integer divide by the switch width, gated by the range check.
    always_comb begin
        in_range = int'(port) < N_PORTS;
        quot     = int'(port) / N_PER;
        sw       = in_range ? SW'(quot) : '0;
    end

endmodule

// File: rtl/clos_mid_pick.sv
// Chooses the lowest-numbered middle switch from a vector of candidates.
// Assumes: bit i of 'free' is 1 when middle switch i is usable.
module clos_mid_pick
    import clos_pkg::*;
#(
    parameter int K_MID = 5,
    localparam int MW   = idx_width(K_MID)
) (
    input  logic [K_MID-1:0] free,
    output logic             found,
    output logic [MW-1:0]    idx
);

    // Scan from the top so that the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = K_MID - 1; i >= 0; i--) begin
            if (free[i]) begin
                found = 1'b1;
                idx   = MW'(i);
            end
        end
    end

endmodule

// File: rtl/clos_link_map.sv
// Busy bitmap for the links between one outer stage and the middle stage.
// One row per outer switch, one bit per middle switch.
// Assumes: a set and a clear in the same cycle never target the same bit.
module clos_link_map
    import clos_pkg::*;
#(
    parameter int M_SW  = 3,
    parameter int K_MID = 5,
    localparam int SW   = idx_width(M_SW),
    localparam int MW   = idx_width(K_MID)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [SW-1:0]         set_sw,
    input  logic [MW-1:0]         set_mid,
    input  logic                  clr_en,
    input  logic [SW-1:0]         clr_sw,
    input  logic [MW-1:0]         clr_mid,
    input  logic [SW-1:0]         rd_sw,
    output logic [K_MID-1:0]      rd_row,
    output logic [M_SW*K_MID-1:0] busy_flat
);

    logic [K_MID-1:0] row_q [M_SW];

    for (genvar r = 0; r < M_SW; r++) begin : g_row
        // Keep this switch's link bits: clear on release, set on allocation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[r] <= '0;
            end else begin
                if (clr_en && int'(clr_sw) == r) begin
                    row_q[r][clr_mid] <= 1'b0;
                end
                if (set_en && int'(set_sw) == r) begin
                    row_q[r][set_mid] <= 1'b1;
                end
            end
        end
        assign busy_flat[r*K_MID +: K_MID] = row_q[r];
    end

    // Read the row of the requested switch.
    always_comb begin
        rd_row = (int'(rd_sw) < M_SW) ? row_q[rd_sw] : '0;
    end

endmodule

// File: rtl/clos_route_alloc.sv
// Connection allocator for a three-stage Clos fabric.
// It assigns each new connection the lowest middle switch that is free on
// both the ingress and the egress side, and answers one clock later.
// Assumes: at most one request per cycle; callers supply any rearrangement.
module clos_route_alloc
    import clos_pkg::*;
#(
    parameter int N_PER = 3,
    parameter int M_SW  = 3,
    parameter int K_MID = 5,
    localparam int N_PORTS = N_PER * M_SW,
    localparam int PW      = idx_width(N_PORTS),
    localparam int SW      = idx_width(M_SW),
    localparam int MW      = idx_width(K_MID)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic [PW-1:0] req_in,
    input  logic [PW-1:0] req_out,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic [MW-1:0] rsp_mid,
    output logic          cfg_strict
);

    localparam bit STRICT = (K_MID >= 2 * N_PER - 1);

    route_op_e op;
    logic [SW-1:0] ig_sw, eg_sw, rec_eg_sw;
    logic in_ok, out_ok, rec_ok;
    logic [PW-1:0] in_idx, out_idx;

    logic [N_PORTS-1:0] in_used_q, out_used_q;
    logic [PW-1:0]      rec_out_q [N_PORTS];
    logic [MW-1:0]      rec_mid_q [N_PORTS];
    logic [PW-1:0]      sel_rec_out;
    logic [MW-1:0]      sel_rec_mid;

    logic [K_MID-1:0] up_row, dn_row, both_free;
    logic [M_SW*K_MID-1:0] up_busy_flat, dn_busy_flat;
    logic pick_found;
    logic [MW-1:0] pick_idx;
    logic conn_ok, disc_ok, do_conn, do_disc;

    assign cfg_strict = STRICT;

    clos_port_map #(.N_PER(N_PER), .M_SW(M_SW)) u_in_map (
        .port(req_in), .sw(ig_sw), .in_range(in_ok)
    );
    clos_port_map #(.N_PER(N_PER), .M_SW(M_SW)) u_out_map (
        .port(req_out), .sw(eg_sw), .in_range(out_ok)
    );
    clos_port_map #(.N_PER(N_PER), .M_SW(M_SW)) u_rec_map (
        .port(sel_rec_out), .sw(rec_eg_sw), .in_range(rec_ok)
    );

    // Safe table indices and the recorded path of the addressed input.
    always_comb begin
        op          = route_op_e'(req_op);
        in_idx      = in_ok  ? req_in  : '0;
        out_idx     = out_ok ? req_out : '0;
        sel_rec_out = rec_out_q[in_idx];
        sel_rec_mid = rec_mid_q[in_idx];
    end

    clos_link_map #(.M_SW(M_SW), .K_MID(K_MID)) u_up_links (
        .clk(clk), .rst_n(rst_n),
        .set_en(do_conn), .set_sw(ig_sw), .set_mid(pick_idx),
        .clr_en(do_disc), .clr_sw(ig_sw), .clr_mid(sel_rec_mid),
        .rd_sw(ig_sw), .rd_row(up_row), .busy_flat(up_busy_flat)
    );
    clos_link_map #(.M_SW(M_SW), .K_MID(K_MID)) u_dn_links (
        .clk(clk), .rst_n(rst_n),
        .set_en(do_conn), .set_sw(eg_sw), .set_mid(pick_idx),
        .clr_en(do_disc), .clr_sw(rec_eg_sw), .clr_mid(sel_rec_mid),
        .rd_sw(eg_sw), .rd_row(dn_row), .busy_flat(dn_busy_flat)
    );

    // A middle switch qualifies only when both of its links are idle.
    assign both_free = ~up_row & ~dn_row;

    clos_mid_pick #(.K_MID(K_MID)) u_pick (
        .free(both_free), .found(pick_found), .idx(pick_idx)
    );

    // Decide whether the request in this cycle is carried out.
    always_comb begin
        conn_ok = in_ok && out_ok && !in_used_q[in_idx]
                  && !out_used_q[out_idx] && pick_found;
        disc_ok = in_ok && in_used_q[in_idx] && rec_ok;
        do_conn = req_valid && (op == ROUTE_CONNECT)    && conn_ok;
        do_disc = req_valid && (op == ROUTE_DISCONNECT) && disc_ok;
    end

    // Port-usage flags: claim on connect, release on disconnect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_used_q  <= '0;
            out_used_q <= '0;
        end else if (do_conn) begin
            in_used_q[in_idx]   <= 1'b1;
            out_used_q[out_idx] <= 1'b1;
        end else if (do_disc) begin
            in_used_q[in_idx]        <= 1'b0;
            out_used_q[sel_rec_out]  <= 1'b0;
        end
    end

    // Path record per input port: output port and middle switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < N_PORTS; p++) begin
                rec_out_q[p] <= '0;
                rec_mid_q[p] <= '0;
            end
        end else if (do_conn) begin
            rec_out_q[in_idx] <= out_idx;
            rec_mid_q[in_idx] <= pick_idx;
        end
    end

    // Registered response, one clock after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_mid   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= do_conn || do_disc;
            if (do_conn) begin
                rsp_mid <= pick_idx;
            end else if (do_disc) begin
                rsp_mid <= sel_rec_mid;
            end else begin
                rsp_mid <= '0;
            end
        end
    end

endmodule

// File: rtl/clos_route_chk.sv
// Property checker for clos_route_alloc, attached with bind below.
// Assumes: it sees the request and response ports and both link bitmaps.
module clos_route_chk
    import clos_pkg::*;
#(
    parameter int N_PER = 3,
    parameter int M_SW  = 3,
    parameter int K_MID = 5,
    localparam int N_PORTS = N_PER * M_SW,
    localparam int PW      = idx_width(N_PORTS),
    localparam int MW      = idx_width(K_MID),
    localparam int NB      = M_SW * K_MID
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_op,
    input logic [PW-1:0] req_in,
    input logic [PW-1:0] req_out,
    input logic          rsp_valid,
    input logic          rsp_ok,
    input logic [MW-1:0] rsp_mid,
    input logic [NB-1:0] up_flat,
    input logic [NB-1:0] dn_flat
);

    logic [NB-1:0] up_q, dn_q;
    logic          op_q;
    int            igq, egq;
    int            up_pos, dn_pos;
    logic          lower_free, picked_was_free, picked_now_busy;

    // Remember the pre-request bitmaps and the request's switch indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= '0;
            dn_q <= '0;
            op_q <= 1'b0;
            igq  <= 0;
            egq  <= 0;
        end else begin
            up_q <= up_flat;
            dn_q <= dn_flat;
            op_q <= req_op;
            igq  <= (int'(req_in)  < N_PORTS) ? int'(req_in)  / N_PER : 0;
            egq  <= (int'(req_out) < N_PORTS) ? int'(req_out) / N_PER : 0;
        end
    end

    // Bit positions of the chosen middle switch and the lower-index scan.
    always_comb begin
        up_pos = igq * K_MID + int'(rsp_mid);
        dn_pos = egq * K_MID + int'(rsp_mid);
        picked_was_free = 1'b0;
        picked_now_busy = 1'b0;
        if (up_pos < NB && dn_pos < NB) begin
            picked_was_free = !up_q[up_pos] && !dn_q[dn_pos];
            picked_now_busy = up_flat[up_pos] && dn_flat[dn_pos];
        end
        lower_free = 1'b0;
        for (int j = 0; j < K_MID; j++) begin
            if (j < int'(rsp_mid) && (igq * K_MID + j) < NB
                && (egq * K_MID + j) < NB) begin
                if (!up_q[igq * K_MID + j] && !dn_q[egq * K_MID + j]) begin
                    lower_free = 1'b1;
                end
            end
        end
    end

    // R1: reset clears the response and every link.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && up_flat == '0 && dn_flat == '0));

    // R2: a request is answered in the next cycle.
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: no response without a request.
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: a granted connect took a middle switch free on both sides, now busy.
    a_r3_pick_was_free: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && op_q == 1'b0)
            |-> (picked_was_free && picked_now_busy));

    // R3: no lower middle switch was free on both sides.
    a_r3_pick_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && op_q == 1'b0) |-> !lower_free);

    // R3: a returned middle index always names an existing middle switch.
    a_r3_mid_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (int'(rsp_mid) < K_MID));

    // R4: a refused request leaves both bitmaps as they were.
    a_r4_refusal_keeps_links: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (up_flat == up_q && dn_flat == dn_q
                                    && rsp_mid == '0));

    // R5: every path holds exactly one uplink and one downlink.
    a_r5_links_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(up_flat) == $countones(dn_flat));

endmodule

bind clos_route_alloc clos_route_chk #(
    .N_PER(N_PER), .M_SW(M_SW), .K_MID(K_MID)
) u_route_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op),
    .req_in(req_in), .req_out(req_out),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_mid(rsp_mid),
    .up_flat(up_busy_flat), .dn_flat(dn_busy_flat)
);

// File: tb/tb_clos_route_alloc.sv
`timescale 1ns/1ps
module tb_clos_route_alloc;

    localparam int NP    = 3;
    localparam int MS    = 3;
    localparam int KM    = 5;
    localparam int NPORT = NP * MS;
    localparam int PW    = $clog2(NPORT);
    localparam int MW    = $clog2(KM);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_op = 1'b0;
    logic [PW-1:0] req_in = '0;
    logic [PW-1:0] req_out = '0;
    logic          rsp_valid, rsp_ok, cfg_strict;
    logic [MW-1:0] rsp_mid;

    always #4 clk = ~clk;

    clos_route_alloc #(.N_PER(NP), .M_SW(MS), .K_MID(KM)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op),
        .req_in(req_in), .req_out(req_out),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_mid(rsp_mid),
        .cfg_strict(cfg_strict)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Behavioural model: path per input, output usage, link occupancy.
    int m_out [NPORT];
    int m_mid [NPORT];
    bit o_used [NPORT];
    bit ub [MS][KM];
    bit db [MS][KM];

    bit    e_valid, e_ok, e_strict;
    int    e_mid;
    string e_tag;

    task automatic chk(input bit cond, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NPORT; p++) begin
            m_out[p] = -1; m_mid[p] = 0; o_used[p] = 0;
        end
        for (int s = 0; s < MS; s++)
            for (int j = 0; j < KM; j++) begin ub[s][j] = 0; db[s][j] = 0; end
        e_valid = 0; e_ok = 0; e_mid = 0; e_strict = 0; e_tag = "R1";
    endtask

    // Compare the outputs with the prediction made one cycle earlier.
    task automatic compare();
        chk(rsp_valid == e_valid, e_tag, "rsp_valid", int'(rsp_valid), int'(e_valid));
        if (e_valid) begin
            chk(rsp_ok == e_ok, e_tag, "rsp_ok", int'(rsp_ok), int'(e_ok));
            chk(int'(rsp_mid) == e_mid, e_tag, "rsp_mid", int'(rsp_mid), e_mid);
            if (e_strict)
                chk(rsp_ok == 1'b1, "R6", "strict connect granted", int'(rsp_ok), 1);
        end
    endtask

    // Drive a request and predict its response from the model.
    task automatic issue(input bit v, input bit op, input int a, input int b);
        int ig, eg, pick;
        req_valid = v; req_op = op; req_in = PW'(a); req_out = PW'(b);
        e_valid = v; e_ok = 0; e_mid = 0; e_strict = 0;
        e_tag = v ? "R3" : "R2";
        if (v && op == 1'b0) begin
            if (a >= NPORT || b >= NPORT) e_tag = "R7";
            else if (m_out[a] >= 0 || o_used[b]) e_tag = "R4";
            else begin
                ig = a / NP; eg = b / NP; pick = -1; e_strict = 1;
                for (int j = KM - 1; j >= 0; j--)
                    if (!ub[ig][j] && !db[eg][j]) pick = j;
                if (pick >= 0) begin
                    e_ok = 1; e_mid = pick;
                    ub[ig][pick] = 1; db[eg][pick] = 1;
                    m_out[a] = b; m_mid[a] = pick; o_used[b] = 1;
                end
            end
        end else if (v) begin
            e_tag = "R5";
            if (a >= NPORT) e_tag = "R7";
            else if (m_out[a] >= 0) begin
                e_ok = 1; e_mid = m_mid[a];
                ub[a / NP][m_mid[a]] = 0;
                db[m_out[a] / NP][m_mid[a]] = 0;
                o_used[m_out[a]] = 0;
                m_out[a] = -1;
            end
        end
    endtask

    task automatic step(input bit v, input bit op, input int a, input int b);
        @(negedge clk);
        compare();
        issue(v, op, a, b);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: response idle while reset is held.
        repeat (4) begin
            @(negedge clk);
            compare();
        end
        chk(cfg_strict == 1'b1, "R6", "cfg_strict", int'(cfg_strict), 1);
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        e_tag = "R1";
        issue(1, 0, 0, 0);       // R1: first connect gets middle 0
        step(1, 0, 1, 1);        // R3: lowest free is middle 1
        step(1, 0, 0, 5);        // R4: input busy
        step(1, 0, 2, 1);        // R4: output busy
        step(1, 0, 9, 2);        // R7: input out of range
        step(1, 0, 2, 12);       // R7: output out of range
        step(1, 1, 4, 3);        // R5: disconnect of idle input
        step(1, 1, 0, 7);        // R5: frees middle 0, req_out ignored
        step(1, 0, 2, 2);        // R5: middle 0 reusable
        step(0, 0, 0, 0);        // R2: idle
        step(0, 0, 0, 0);
        step(1, 1, 11, 0);       // R7: disconnect out of range
        // Random churn weighted to connect, to drive occupancy high.
        for (int i = 0; i < 6000; i++) begin
            bit v, op;
            v  = ($urandom_range(0, 9) < 8);
            op = ($urandom_range(0, 9) < 4);
            step(v, op, $urandom_range(0, 10), $urandom_range(0, 10));
        end
        for (int p = 0; p < NPORT; p++) step(1, 1, p, 0);  // R5: tear down
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        finished = 1;
        summary();
        $finish;
    end

endmodule